// File: doc/BRIEF.md
# Reconfigurable Multi-LFSR Keystream Generator

This block produces one keystream bit per clock from several linear feedback shift registers that run side by side. Each register lane has its own tap-mask register, so the feedback polynomial is chosen at run time rather than fixed in the logic. A single seed word holds two fields. A small select field picks one polynomial from an internal table, and that polynomial is written into the tap-mask register of every lane. The rest of the seed gives the starting state of each lane.

Each clock the lanes may advance by one step. The keystream bit is the XOR of the top bit of every lane. The block XORs this bit with a message bit to give a ciphertext bit. Every tap-mask and state flip-flop is part of one mux-D scan chain. This chain lets a tester shift any state in or out while scan enable is held high.

Top module: `mlfsr_keystream`

## Requirements
- R1: While reset is asserted and after it is released, `ready_o` is 0 and every tap-mask and state bit is 0. As a result, `key_o` and `scan_out` are both 0 until the first load or scan.
- R2: A cycle with `load_i` high and `scan_en` low captures `seed_i`, and `ready_o` is 0 after that edge. On the next edge with `scan_en` low, the lanes are written and `ready_o` goes to 1. It then holds until the next accepted load.
- R3: Seed fields: `seed_i[2:0]` selects the polynomial. `seed_i[3+16*i +: 16]` becomes the starting state of lane i, for i = 0 to 3.
- R4: The table entries are the following tap masks, with the select value first in each pair: 0→0x8805, 1→0x8016, 2→0xD008, 3→0xB400, 4→0x802D, 5→0x9101, 6→0xA0C1, 7→0xC441. The selected entry goes into all four lanes.
- R5: An edge with `ready_o`=1, `step_i`=1 and `scan_en`=0 steps every lane: state becomes {state[14:0], parity(state & taps)}. When `step_i`=0 or `ready_o`=0 outside a write or a scan, the state and taps hold.
- R6: `key_o` is the XOR of bit 15 of every lane state. `ct_o` equals `msg_i` XOR `key_o`, with no clock delay.
- R7: While `scan_en` is 1, each edge shifts the chain by one bit. The order is `scan_in` → lane0 state[0..15] → lane0 taps[0..15] → lane1 state[0] → … → lane3 taps[15]. `scan_out` shows lane3 taps[15]. The shift takes priority over a pending write and over stepping.
- R8: `load_i` is ignored while `scan_en` is 1, so `ready_o` does not change. A write still pending when scan starts waits until `scan_en` returns to 0.
- R9: Every table entry has bit 15 set. After any write, bit 15 of every lane's taps is therefore 1, so the step can always be undone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_en | input | 1 | 1 = shift the scan chain, 0 = functional operation |
| scan_in | input | 1 | Serial scan data into lane 0 state bit 0 |
| scan_out | output | 1 | Serial scan data from lane 3 taps bit 15 |
| load_i | input | 1 | Seed load strobe |
| seed_i | input | 67 | Polynomial select in bits 2:0, lane start states above it |
| step_i | input | 1 | Request to advance all lanes one step |
| msg_i | input | 1 | Message bit |
| ready_o | output | 1 | Lanes hold a loaded seed |
| key_o | output | 1 | Keystream bit |
| ct_o | output | 1 | Ciphertext bit |

## Verification
The assertions assume that `scan_en`, `load_i` and `step_i` are clean levels sampled on the rising edge. They also assume that the tap masks handed to the lanes at a write come only from the internal table; the top-tap property relies on this. The stimulus interleaves short random scan bursts, seed loads at random times, and step requests in most cycles. Load requests therefore land during scans and while writes are pending. Directed passes load each of the eight selections and unload the full chain with the scan shift, so that table contents and chain order are seen at the scan output.

// File: rtl/mlk_pkg.sv
package mlk_pkg;
  localparam int unsigned POLY_W = 16;
  localparam int unsigned SEL_W  = 3;

  // Tap-mask table: bit (POLY_W-1-e) is set for each polynomial term x^e, e < POLY_W.
  function automatic logic [POLY_W-1:0] tap_table(input logic [SEL_W-1:0] idx);
    logic [POLY_W-1:0] m;
    case (idx)
      3'd0:    m = 16'h8805;
      3'd1:    m = 16'h8016;
      3'd2:    m = 16'hD008;
      3'd3:    m = 16'hB400;
      3'd4:    m = 16'h802D;
      3'd5:    m = 16'h9101;
      3'd6:    m = 16'hA0C1;
      default: m = 16'hC441;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/kstr_seq.sv
module kstr_seq #(
  parameter int unsigned SEED_W = 67
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              load_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_o,
  output logic              wr_en_o,
  output logic              ready_o
);
  logic              pend_q, pend_d;
  logic              rdy_q, rdy_d;
  logic [SEED_W-1:0] seed_q;
  logic              load_acc;

  assign load_acc = load_i & ~scan_en;
  assign wr_en_o  = pend_q & ~scan_en;
  assign seed_o   = seed_q;
  assign ready_o  = rdy_q;

  always_comb begin
    pend_d = pend_q;
    rdy_d  = rdy_q;
    if (wr_en_o) begin
      pend_d = 1'b0;
      rdy_d  = 1'b1;
    end
    if (load_acc) begin
      pend_d = 1'b1;
      rdy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      rdy_q  <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seed_q <= '0;
    else if (load_acc) seed_q <= seed_i;
  end

  assert_load_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !scan_en) |=> !ready_o);
  assert_write_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !load_i) |=> ready_o);
  assert_scan_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !ready_o) |=> !ready_o);
  assert_scan_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && ready_o) |=> ready_o);
endmodule

// File: rtl/kstr_lane.sv
module kstr_lane #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_en,
  input  logic         scan_si,
  input  logic         wr_en,
  input  logic [W-1:0] wr_taps,
  input  logic [W-1:0] wr_state,
  input  logic         step_en,
  output logic         msb_o,
  output logic         scan_so
);
  logic [W-1:0] cfg_q, cfg_d;
  logic [W-1:0] sr_q, sr_d;
  logic         upd;

  assign upd     = scan_en | wr_en | step_en;
  assign msb_o   = sr_q[W-1];
  assign scan_so = cfg_q[W-1];

  always_comb begin
    cfg_d = cfg_q;
    sr_d  = sr_q;
    if (scan_en) begin
      cfg_d = {cfg_q[W-2:0], sr_q[W-1]};
      sr_d  = {sr_q[W-2:0], scan_si};
    end else if (wr_en) begin
      cfg_d = wr_taps;
      sr_d  = wr_state;
    end else if (step_en) begin
      sr_d  = {sr_q[W-2:0], ^(sr_q & cfg_q)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sr_q  <= '0;
    end else if (upd) begin
      cfg_q <= cfg_d;
      sr_q  <= sr_d;
    end
  end

  assert_tap_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !scan_en) |=> cfg_q[W-1]);
  assert_step_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wr_en && !scan_en) |=> (sr_q[W-1:1] == $past(sr_q[W-2:0])) && $stable(cfg_q));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !wr_en && !step_en) |=> $stable(sr_q) && $stable(cfg_q));
  assert_scan_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (sr_q[0] == $past(scan_si)) && (cfg_q[0] == $past(sr_q[W-1])));
endmodule

// File: rtl/mlfsr_keystream.sv
module mlfsr_keystream #(
  parameter int unsigned NUM_LFSR = 4,
  parameter int unsigned WIDTH    = mlk_pkg::POLY_W,
  parameter int unsigned SEL_W    = mlk_pkg::SEL_W,
  parameter int unsigned SEED_W   = SEL_W + NUM_LFSR * WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic              load_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              step_i,
  input  logic              msg_i,
  output logic              ready_o,
  output logic              key_o,
  output logic              ct_o
);
  localparam int unsigned CHAIN_LEN = 2 * NUM_LFSR * WIDTH;

  logic [1:0]          rst_sync_q;
  logic                rst_ni;
  logic [SEED_W-1:0]   seed_q;
  logic                wr_en;
  logic                step_en;
  logic [WIDTH-1:0]    taps;
  logic [NUM_LFSR:0]   link;
  logic [NUM_LFSR-1:0] msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  kstr_seq #(.SEED_W(SEED_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_ni),
    .scan_en (scan_en),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .seed_o  (seed_q),
    .wr_en_o (wr_en),
    .ready_o (ready_o)
  );

  assign taps    = mlk_pkg::tap_table(seed_q[SEL_W-1:0]);
  assign step_en = step_i & ready_o & ~scan_en;
  assign link[0] = scan_in;

  for (genvar i = 0; i < NUM_LFSR; i++) begin : g_lane
    kstr_lane #(.W(WIDTH)) u_lane (
      .clk      (clk),
      .rst_n    (rst_ni),
      .scan_en  (scan_en),
      .scan_si  (link[i]),
      .wr_en    (wr_en),
      .wr_taps  (taps),
      .wr_state (seed_q[SEL_W + i*WIDTH +: WIDTH]),
      .step_en  (step_en),
      .msb_o    (msb[i]),
      .scan_so  (link[i+1])
    );
  end

  assign scan_out = link[NUM_LFSR];
  assign key_o    = ^msb;
  assign ct_o     = msg_i ^ key_o;

  initial begin
    assert (CHAIN_LEN == 2 * NUM_LFSR * WIDTH && WIDTH > 1);
  end

  assert_no_step_unready_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ready_o && !scan_en && !wr_en) |=> $stable(key_o) && $stable(scan_out));
endmodule

// File: tb/sim_mlfsr_keystream.sv
`timescale 1ns/1ps
module sim_mlfsr_keystream;
  localparam int S = 4;
  localparam int W = 16;
  localparam int SW = 3 + S * W;

  logic clk = 1'b0;
  logic rst_n;
  logic scan_en, scan_in, load_i, step_i, msg_i;
  logic [SW-1:0] seed_i;
  logic scan_out, ready_o, key_o, ct_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] mcfg [S];
  logic [W-1:0] msr  [S];
  logic         mpend, mready;
  logic [SW-1:0] mseed;

  always #10 clk = ~clk;

  mlfsr_keystream u0 (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .load_i(load_i), .seed_i(seed_i), .step_i(step_i),
    .msg_i(msg_i), .ready_o(ready_o), .key_o(key_o), .ct_o(ct_o)
  );

  function automatic logic [W-1:0] exp_taps(input logic [2:0] sel);
    case (sel)
      3'd0: return 16'h8805;
      3'd1: return 16'h8016;
      3'd2: return 16'hD008;
      3'd3: return 16'hB400;
      3'd4: return 16'h802D;
      3'd5: return 16'h9101;
      3'd6: return 16'hA0C1;
      default: return 16'hC441;
    endcase
  endfunction

  function automatic logic exp_key();
    logic k = 1'b0;
    for (int i = 0; i < S; i++) k ^= msr[i][W-1];
    return k;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < S; i++) begin mcfg[i] = '0; msr[i] = '0; end
    mpend = 1'b0; mready = 1'b0; mseed = '0;
  endtask

  task automatic model_edge();
    logic [W-1:0] oc [S];
    logic [W-1:0] os [S];
    logic wr, st, acc, si;
    for (int i = 0; i < S; i++) begin oc[i] = mcfg[i]; os[i] = msr[i]; end
    acc = load_i & ~scan_en;
    wr  = mpend & ~scan_en;
    st  = step_i & mready & ~scan_en;
    for (int i = 0; i < S; i++) begin
      if (scan_en) begin
        si = (i == 0) ? scan_in : oc[i-1][W-1];
        mcfg[i] = {oc[i][W-2:0], os[i][W-1]};
        msr[i]  = {os[i][W-2:0], si};
      end else if (wr) begin
        mcfg[i] = exp_taps(mseed[2:0]);
        msr[i]  = mseed[3 + W*i +: W];
      end else if (st) begin
        msr[i]  = {os[i][W-2:0], ^(os[i] & oc[i])};
      end
    end
    if (wr) begin mpend = 1'b0; mready = 1'b1; end
    if (acc) begin mpend = 1'b1; mready = 1'b0; mseed = seed_i; end
  endtask

  task automatic cyc(input string so_tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2", "ready_o", ready_o, mready);
    chk("R5", "key_o", key_o, exp_key());
    chk("R6", "ct_o", ct_o, msg_i ^ exp_key());
    chk(so_tag, "scan_out", scan_out, mcfg[S-1][W-1]);
  endtask

  function automatic logic [SW-1:0] rnd_seed();
    return {$urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] sd;
    logic kx;
    void'($urandom(32'd7351));
    rst_n = 1'b0; scan_en = 1'b0; scan_in = 1'b0; load_i = 1'b0;
    step_i = 1'b0; msg_i = 1'b0; seed_i = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", "ready_o in reset", ready_o, 1'b0);
    chk("R1", "key_o in reset", key_o, 1'b0);
    chk("R1", "scan_out in reset", scan_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) cyc("R1");
    step_i = 1'b1;
    cyc("R1");
    chk("R1", "key_o idle after reset", key_o, 1'b0);
    step_i = 1'b0;

    // Load each table selection, then unload the whole chain.
    for (int sel = 0; sel < 8; sel++) begin
      sd = rnd_seed();
      sd[2:0] = sel[2:0];
      seed_i = sd; load_i = 1'b1;
      cyc("R2");
      chk("R2", "ready_o after strobe", ready_o, 1'b0);
      load_i = 1'b0; seed_i = rnd_seed();
      cyc("R2");
      chk("R2", "ready_o after write", ready_o, 1'b1);
      kx = 1'b0;
      for (int i = 0; i < S; i++) kx ^= sd[3 + W*i + W - 1];
      chk("R3", "key_o from seed fields", key_o, kx);
      chk("R9", "lane3 top tap", scan_out, 1'b1);
      scan_en = 1'b1;
      for (int b = 0; b < 2*S*W; b++) begin
        scan_in = $urandom_range(0, 1);
        cyc("R4");
      end
      scan_en = 1'b0;
    end

    // Load attempt during scan is ignored.
    scan_en = 1'b1; load_i = 1'b1; seed_i = rnd_seed();
    cyc("R7");
    chk("R8", "ready_o after load during scan", ready_o, 1'b1);
    scan_en = 1'b0; load_i = 1'b0;
    cyc("R8");
    cyc("R8");
    chk("R8", "ready_o stays after ignored load", ready_o, 1'b1);

    // Pending write deferred by scan.
    seed_i = rnd_seed(); load_i = 1'b1;
    cyc("R8");
    load_i = 1'b0; scan_en = 1'b1;
    repeat (5) cyc("R8");
    chk("R8", "ready_o held low while scanning", ready_o, 1'b0);
    scan_en = 1'b0;
    cyc("R8");
    chk("R8", "ready_o after deferred write", ready_o, 1'b1);

    // Holding step_i low keeps state.
    step_i = 1'b0;
    repeat (6) begin msg_i = $urandom_range(0, 1); cyc("R5"); end

    // Random mix.
    for (int t = 0; t < 6000; t++) begin
      scan_en = ($urandom_range(0, 7) == 0);
      load_i  = ($urandom_range(0, 39) == 0);
      step_i  = ($urandom_range(0, 3) != 0);
      msg_i   = $urandom_range(0, 1);
      scan_in = $urandom_range(0, 1);
      seed_i  = rnd_seed();
      cyc("R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule